// File: doc/BRIEF.md
# Floating-Point Store Twin-Issue Interlock

This block accepts instructions from the rename stage and places each floating-point store into two issue queues at once: an integer/memory-side queue that will later send the store to the memory unit, and a floating-point queue that supplies the store data. The integer-side copy is held back by a per-entry hold bit. The floating-point copy requests issue once its data register is predicted to become ready. When that copy is granted, it releases its twin by an indexed write into the integer-side queue. The integer queue therefore never needs to track floating-point register readiness.

Non-store instructions occupy only the integer-side queue and are never held. A store that is the target of a replay trap is written into both queues, but its integer-side copy starts with the hold bit clear. A flush empties both queues together. All issue requests and the pairing links are registered outputs.

Top module: `fst_pair_iq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `iq_req`, `fq_req` and `fq_link` are all zero.
- R2: A dispatch with `disp_fst`=0 takes the lowest-numbered free integer-side entry when one exists. That entry's `iq_req` bit is 1 in the cycle after the dispatch edge.
- R3: A dispatch with `disp_fst`=1 and `disp_replay`=0 takes the lowest free entry in each queue. The integer-side copy raises no `iq_req` until its twin is granted.
- R4: A dispatch with `disp_fst`=1 and `disp_replay`=1 takes an entry in both queues. Its integer-side copy requests in the next cycle. A later grant of its floating-point copy changes no `iq_req` bit.
- R5: `fq_req[i]` is 1 exactly when entry i is occupied after an edge and `ready_soon[src]` was 1 at that edge, where src is the entry's `disp_src` register number.
- R6: Bits [i*IQ_IW +: IQ_IW] of `fq_link` hold the integer-side index of floating-point entry i's twin while entry i is occupied, and zero otherwise.
- R7: `fq_gnt_vld`=1 with `fq_gnt_idx`=i while `fq_req[i]`=1 frees entry i. If the entry was dispatched without replay, it also clears its twin's hold bit, so the twin's `iq_req` is 1 in the next cycle.
- R8: `iq_gnt_vld`=1 with `iq_gnt_idx`=j while `iq_req[j]`=1 frees entry j. Its request drops in the next cycle, and the entry can be allocated again from the following dispatch.
- R9: A grant whose indexed request bit is 0 has no effect on either queue.
- R10: A dispatch is dropped if the integer-side queue is full, or if it is a store and the floating-point queue is full.
- R11: `flush`=1 empties both queues at the edge, overriding any dispatch or grant in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty both queues |
| disp_vld | input | 1 | Instruction dispatched this cycle |
| disp_fst | input | 1 | Dispatched instruction is a floating-point store |
| disp_replay | input | 1 | Store is the target of a replay trap |
| disp_src | input | REG_W | Physical register holding the store data |
| ready_soon | input | 2**REG_W | Per-register prediction that the register becomes ready next |
| iq_gnt_vld | input | 1 | Integer-side issue grant |
| iq_gnt_idx | input | IQ_IW | Granted integer-side entry |
| fq_gnt_vld | input | 1 | Floating-point issue grant |
| fq_gnt_idx | input | FQ_IW | Granted floating-point entry |
| iq_req | output | IQ_DEPTH | Integer-side issue requests |
| fq_req | output | FQ_DEPTH | Floating-point issue requests |
| fq_link | output | FQ_DEPTH*IQ_IW | Twin index for each floating-point entry |

## Verification
Directed sequences cover four cases separately: a plain dispatch, a held store, a replay store, and a store released by its twin's grant. Comparing them shows whether the hold bit is set, skipped or cleared in the right entry. Grants aimed at idle entries, dispatches into full queues and flushes coinciding with traffic show that each gate works on its own. A long sweep over a four-entry and two-entry configuration with eight registers then mixes every input at random each cycle. It compares all outputs with an arithmetic model of the queues, which exposes errors in allocation order, pairing links and readiness lookups.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_PLAIN  = 2'd1,
    K_STORE  = 2'd2,
    K_REPLAY = 2'd3
  } disp_kind_e;
endpackage

// File: rtl/fsi_pick.sv
module fsi_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  busy,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/fsi_iq.sv
module fsi_iq #(
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             alloc_en,
  input  logic [IW-1:0]    alloc_idx,
  input  logic             alloc_hold,
  input  logic             gnt_en,
  input  logic [IW-1:0]    gnt_idx,
  input  logic             wake_en,
  input  logic [IW-1:0]    wake_idx,
  output logic [DEPTH-1:0] occ,
  output logic [DEPTH-1:0] req_q
);
  logic [DEPTH-1:0] hold_q, occ_n, hold_n;

  always_comb begin
    occ_n  = occ;
    hold_n = hold_q;
    if (gnt_en)  occ_n[gnt_idx]   = 1'b0;
    if (wake_en) hold_n[wake_idx] = 1'b0;
    if (alloc_en) begin
      occ_n[alloc_idx]  = 1'b1;
      hold_n[alloc_idx] = alloc_hold;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      occ    <= '0;
      hold_q <= '0;
      req_q  <= '0;
    end else begin
      occ    <= occ_n;
      hold_q <= hold_n;
      req_q  <= occ_n & ~hold_n;
    end
  end
endmodule

// File: rtl/fsi_fq.sv
module fsi_fq #(
  parameter int DEPTH = 4,
  parameter int LW    = 3,
  parameter int REG_W = 5,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NREG = 1 << REG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                alloc_en,
  input  logic [IW-1:0]       alloc_idx,
  input  logic [REG_W-1:0]    alloc_src,
  input  logic [LW-1:0]       alloc_link,
  input  logic                alloc_lv,
  input  logic                gnt_en,
  input  logic [IW-1:0]       gnt_idx,
  input  logic [NREG-1:0]     ready_soon,
  output logic [DEPTH-1:0]    occ,
  output logic [DEPTH-1:0]    req_q,
  output logic [DEPTH*LW-1:0] link_flat,
  output logic                wake_en,
  output logic [LW-1:0]       wake_idx
);
  logic [REG_W-1:0] src_mem [DEPTH];
  logic [LW-1:0]    link_q  [DEPTH];
  logic [LW-1:0]    link_n  [DEPTH];
  logic [DEPTH-1:0] lv_q, lv_n, occ_n, req_n;

  always_ff @(posedge clk) begin
    if (alloc_en) src_mem[alloc_idx] <= alloc_src;
  end

  always_comb begin
    occ_n = occ;
    lv_n  = lv_q;
    for (int i = 0; i < DEPTH; i++) link_n[i] = link_q[i];
    if (gnt_en) begin
      occ_n[gnt_idx]  = 1'b0;
      lv_n[gnt_idx]   = 1'b0;
      link_n[gnt_idx] = '0;
    end
    if (alloc_en) begin
      occ_n[alloc_idx]  = 1'b1;
      lv_n[alloc_idx]   = alloc_lv;
      link_n[alloc_idx] = alloc_link;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_en && alloc_idx == IW'(i))
        req_n[i] = occ_n[i] & ready_soon[alloc_src];
      else
        req_n[i] = occ_n[i] & ready_soon[src_mem[i]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      occ   <= '0;
      lv_q  <= '0;
      req_q <= '0;
      for (int i = 0; i < DEPTH; i++) link_q[i] <= '0;
    end else begin
      occ   <= occ_n;
      lv_q  <= lv_n;
      req_q <= req_n;
      for (int i = 0; i < DEPTH; i++) link_q[i] <= link_n[i];
    end
  end

  assign wake_en  = gnt_en & lv_q[gnt_idx];
  assign wake_idx = link_q[gnt_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_link
    assign link_flat[g*LW +: LW] = link_q[g];
  end
endmodule

// File: rtl/fst_pair_iq.sv
module fst_pair_iq
  import fsi_pkg::*;
#(
  parameter int IQ_DEPTH = 8,
  parameter int FQ_DEPTH = 4,
  parameter int REG_W    = 5,
  localparam int IQ_IW   = (IQ_DEPTH > 1) ? $clog2(IQ_DEPTH) : 1,
  localparam int FQ_IW   = (FQ_DEPTH > 1) ? $clog2(FQ_DEPTH) : 1,
  localparam int NREG    = 1 << REG_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush,
  input  logic                      disp_vld,
  input  logic                      disp_fst,
  input  logic                      disp_replay,
  input  logic [REG_W-1:0]          disp_src,
  input  logic [NREG-1:0]           ready_soon,
  input  logic                      iq_gnt_vld,
  input  logic [IQ_IW-1:0]          iq_gnt_idx,
  input  logic                      fq_gnt_vld,
  input  logic [FQ_IW-1:0]          fq_gnt_idx,
  output logic [IQ_DEPTH-1:0]       iq_req,
  output logic [FQ_DEPTH-1:0]       fq_req,
  output logic [FQ_DEPTH*IQ_IW-1:0] fq_link
);
  logic [IQ_DEPTH-1:0] iq_occ;
  logic [FQ_DEPTH-1:0] fq_occ;
  logic                iq_found, fq_found;
  logic [IQ_IW-1:0]    iq_free, wake_idx;
  logic [FQ_IW-1:0]    fq_free;
  logic                take_iq, take_fq, iq_gnt_ok, fq_gnt_ok, wake_en;
  disp_kind_e          kind;

  always_comb begin
    if (!disp_vld)     kind = K_NONE;
    else if (!disp_fst) kind = K_PLAIN;
    else if (disp_replay) kind = K_REPLAY;
    else               kind = K_STORE;
  end

  fsi_pick #(.N(IQ_DEPTH)) u_pick_iq (.busy(iq_occ), .found(iq_found), .idx(iq_free));
  fsi_pick #(.N(FQ_DEPTH)) u_pick_fq (.busy(fq_occ), .found(fq_found), .idx(fq_free));

  assign take_iq   = (kind == K_PLAIN) ? iq_found
                   : (kind != K_NONE) && iq_found && fq_found;
  assign take_fq   = take_iq && (kind == K_STORE || kind == K_REPLAY);
  assign iq_gnt_ok = iq_gnt_vld && iq_req[iq_gnt_idx];
  assign fq_gnt_ok = fq_gnt_vld && fq_req[fq_gnt_idx];

  fsi_iq #(.DEPTH(IQ_DEPTH)) u_iq (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc_en(take_iq), .alloc_idx(iq_free), .alloc_hold(kind == K_STORE),
    .gnt_en(iq_gnt_ok), .gnt_idx(iq_gnt_idx),
    .wake_en(wake_en), .wake_idx(wake_idx),
    .occ(iq_occ), .req_q(iq_req)
  );

  fsi_fq #(.DEPTH(FQ_DEPTH), .LW(IQ_IW), .REG_W(REG_W)) u_fq (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc_en(take_fq), .alloc_idx(fq_free), .alloc_src(disp_src),
    .alloc_link(iq_free), .alloc_lv(kind == K_STORE),
    .gnt_en(fq_gnt_ok), .gnt_idx(fq_gnt_idx), .ready_soon(ready_soon),
    .occ(fq_occ), .req_q(fq_req), .link_flat(fq_link),
    .wake_en(wake_en), .wake_idx(wake_idx)
  );
endmodule

// File: rtl/fsi_chk.sv
module fsi_chk #(
  parameter int IQ_DEPTH = 8,
  parameter int FQ_DEPTH = 4,
  parameter int REG_W    = 5,
  localparam int IQ_IW   = (IQ_DEPTH > 1) ? $clog2(IQ_DEPTH) : 1,
  localparam int FQ_IW   = (FQ_DEPTH > 1) ? $clog2(FQ_DEPTH) : 1,
  localparam int NREG    = 1 << REG_W
) (
  input logic                clk,
  input logic                rst,
  input logic                flush,
  input logic [NREG-1:0]     ready_soon,
  input logic                iq_gnt_vld,
  input logic [IQ_IW-1:0]    iq_gnt_idx,
  input logic                fq_gnt_vld,
  input logic [FQ_IW-1:0]    fq_gnt_idx,
  input logic [IQ_DEPTH-1:0] iq_req,
  input logic [FQ_DEPTH-1:0] fq_req
);
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (iq_req == '0 && fq_req == '0));

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> (iq_req == '0 && fq_req == '0));

  a_r8_iq_grant_drops: assert property (@(posedge clk) disable iff (rst)
    (iq_gnt_vld && iq_req[iq_gnt_idx] && !flush) |=> !iq_req[$past(iq_gnt_idx)]);

  a_r7_fq_grant_drops: assert property (@(posedge clk) disable iff (rst)
    (fq_gnt_vld && fq_req[fq_gnt_idx] && !flush) |=> !fq_req[$past(fq_gnt_idx)]);

  a_r5_no_ready_no_req: assert property (@(posedge clk) disable iff (rst)
    (ready_soon == '0) |=> (fq_req == '0));
endmodule

bind fst_pair_iq fsi_chk #(.IQ_DEPTH(IQ_DEPTH), .FQ_DEPTH(FQ_DEPTH), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .ready_soon(ready_soon),
  .iq_gnt_vld(iq_gnt_vld), .iq_gnt_idx(iq_gnt_idx),
  .fq_gnt_vld(fq_gnt_vld), .fq_gnt_idx(fq_gnt_idx),
  .iq_req(iq_req), .fq_req(fq_req)
);

// File: tb/fst_pair_iq_tb.sv
module fst_pair_iq_tb;
  localparam int IQD = 4, FQD = 2, RW = 3, NR = 8, IW = 2, FW = 1;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic disp_vld = 0, disp_fst = 0, disp_replay = 0;
  logic [RW-1:0] disp_src = '0;
  logic [NR-1:0] ready_soon = '0;
  logic iq_gnt_vld = 0, fq_gnt_vld = 0;
  logic [IW-1:0] iq_gnt_idx = '0;
  logic [FW-1:0] fq_gnt_idx = '0;
  logic [IQD-1:0] iq_req;
  logic [FQD-1:0] fq_req;
  logic [FQD*IW-1:0] fq_link;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  bit m_iv[IQD], m_ih[IQD], m_fv[FQD], m_flv[FQD];
  int m_fs[FQD], m_fl[FQD];
  logic [IQD-1:0] e_iq = '0;
  logic [FQD-1:0] e_fq = '0;
  logic [FQD*IW-1:0] e_link = '0;

  always #10 clk = ~clk;

  fst_pair_iq #(.IQ_DEPTH(IQD), .FQ_DEPTH(FQD), .REG_W(RW)) u_dut (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < IQD; i++) begin m_iv[i] = 0; m_ih[i] = 0; end
    for (int i = 0; i < FQD; i++) begin m_fv[i] = 0; m_flv[i] = 0; m_fs[i] = 0; m_fl[i] = 0; end
  endtask

  task automatic step(string tag, bit v, bit f, bit r, int src, logic [NR-1:0] rdy,
                      bit ig, int igi, bit fg, int fgi, bit fl);
    int ifree, ffree;
    bit take;
    disp_vld = v; disp_fst = f; disp_replay = r; disp_src = RW'(src);
    ready_soon = rdy; iq_gnt_vld = ig; iq_gnt_idx = IW'(igi);
    fq_gnt_vld = fg; fq_gnt_idx = FW'(fgi); flush = fl;
    ifree = -1; ffree = -1;
    for (int i = IQD - 1; i >= 0; i--) if (!m_iv[i]) ifree = i;
    for (int i = FQD - 1; i >= 0; i--) if (!m_fv[i]) ffree = i;
    if (fl) model_reset();
    else begin
      if (ig && e_iq[igi]) m_iv[igi] = 0;
      if (fg && e_fq[fgi]) begin
        if (m_flv[fgi]) m_ih[m_fl[fgi]] = 0;
        m_fv[fgi] = 0; m_flv[fgi] = 0; m_fl[fgi] = 0;
      end
      take = v && ifree >= 0 && (!f || ffree >= 0);
      if (take) begin
        m_iv[ifree] = 1; m_ih[ifree] = f && !r;
        if (f) begin
          m_fv[ffree] = 1; m_flv[ffree] = !r; m_fs[ffree] = src; m_fl[ffree] = ifree;
        end
      end
    end
    for (int i = 0; i < IQD; i++) e_iq[i] = m_iv[i] && !m_ih[i];
    for (int i = 0; i < FQD; i++) begin
      e_fq[i] = m_fv[i] && rdy[m_fs[i]];
      e_link[i*IW +: IW] = IW'(m_fl[i]);
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "iq_req", 32'(iq_req), 32'(e_iq));
    chk(tag, "fq_req", 32'(fq_req), 32'(e_fq));
    chk(tag, "fq_link", 32'(fq_link), 32'(e_link));
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", "iq_req in reset", 32'(iq_req), 0);
    chk("R1", "fq_req in reset", 32'(fq_req), 0);
    rst = 1'b0;
    step("R1", 0, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0);
    // plain op lands in entry 0, requests at once
    step("R2", 1, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0);
    chk("R2", "plain request", 32'(iq_req), 32'h1);
    // held store: IQ entry 1, FQ entry 0 linked to 1, src 2 not ready
    step("R3", 1, 1, 0, 2, 8'h00, 0, 0, 0, 0, 0);
    chk("R3", "held twin", 32'(iq_req), 32'h1);
    chk("R6", "link", 32'(fq_link), 32'h1);
    step("R5", 0, 0, 0, 0, 8'h04, 0, 0, 0, 0, 0);
    chk("R5", "ready lookup", 32'(fq_req), 32'h1);
    // grant to held IQ entry is ignored
    step("R9", 0, 0, 0, 0, 8'h04, 1, 1, 0, 0, 0);
    chk("R9", "idle grant", 32'(iq_req), 32'h1);
    step("R7", 0, 0, 0, 0, 8'h00, 0, 0, 1, 0, 0);
    chk("R7", "twin released", 32'(iq_req), 32'h3);
    step("R8", 0, 0, 0, 0, 8'h00, 1, 1, 0, 0, 0);
    chk("R8", "entry freed", 32'(iq_req), 32'h1);
    // replay store reuses entry 1, no hold
    step("R4", 1, 1, 1, 5, 8'h20, 0, 0, 0, 0, 0);
    chk("R4", "replay not held", 32'(iq_req), 32'h3);
    step("R4", 0, 0, 0, 0, 8'h00, 0, 0, 1, 0, 0);
    chk("R4", "replay twin grant", 32'(iq_req), 32'h3);
    // fill FQ then a third store is dropped
    step("R10", 1, 1, 0, 1, 8'h00, 0, 0, 0, 0, 0);
    step("R10", 1, 1, 0, 1, 8'h00, 0, 0, 0, 0, 0);
    step("R10", 1, 1, 0, 1, 8'h00, 0, 0, 0, 0, 0);
    chk("R10", "store dropped", 32'(iq_req), 32'h3);
    step("R10", 1, 0, 0, 0, 8'h02, 0, 0, 0, 0, 0);
    step("R10", 1, 0, 0, 0, 8'h02, 0, 0, 0, 0, 0);
    chk("R10", "plain dropped when full", 32'(fq_req), 32'h3);
    step("R11", 1, 0, 0, 0, 8'hff, 1, 0, 1, 0, 1);
    chk("R11", "flush", 32'(iq_req), 0);
    for (int k = 0; k < 4000; k++) begin
      int u;
      u = $urandom;
      step("R3 R5 R6 sweep", u[0], u[1], u[2] & u[3], int'(u[6:4]), NR'(u[15:8]),
           u[16], int'(u[18:17]), u[19], int'(u[20]), u[31:26] == 0);
    end
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule